// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port with Reset Domains

This block is an eight-bit general-purpose I/O port that a processor reaches through a small register interface. The interface has an address, a write strobe, a read strobe and a data bus. On the pad side the port drives an output value and a per-bit output enable, and it samples the pin levels through a synchroniser. Two storage registers set the port's behaviour. A direction register makes each bit an output or an input, and an output data register holds the levels the port drives. A third address gives a read-only view of the port. In that view each output bit returns its latched output value and each input bit returns the synchronised pin level.

Four control inputs decide which state survives. A power-on reset, which is asynchronous and active low, clears both registers. A hardware standby input clears both registers while it is high and floats every pin. A manual reset keeps both registers and blocks register access. A software standby indication also keeps both registers and blocks writes. A chip uses the port by writing the direction and data registers and polling the port-read view.

Top module: `gpio_port`

## Requirements
- R1: A write with the address equal to DATA_ADDR (default 1) loads the output data register on the rising edge where the write strobe is sampled high. `pin_out` shows the new value from that edge on.
- R2: A write with the address equal to DIR_ADDR (default 0) loads the direction register. A direction bit of 1 drives the matching `pin_oe` bit high, and a bit of 0 drives it low.
- R3: A read of DIR_ADDR returns 0x00. A read of an address that is not mapped (default 3) also returns 0x00.
- R4: A read of PIN_ADDR (default 2) returns, for each bit, the output data bit when the direction bit is 1 and the synchronised pin level when the direction bit is 0.
- R5: A write to PIN_ADDR or to an unmapped address changes neither the direction register nor the data register.
- R6: While `por_n` is low, the direction register, the data register, the synchroniser and `rdata` are all 0. This takes effect without waiting for a clock edge.
- R7: A clock edge with `hw_stby` high clears the direction and data registers, and writes are ignored while `hw_stby` is high. `pin_oe` is all zeros at every moment `hw_stby` is high.
- R8: While `mrst_n` is low, both registers keep their values, writes are ignored, and `rdata` is 0x00. After `mrst_n` returns high, the earlier contents can be read back.
- R9: While `sw_stby` is high, both registers keep their values and writes are ignored.
- R10: The pin inputs pass through a SYNC_STAGES-flop synchroniser (default 2). After a pin changes, reads sampled at the first and second rising edges return the old level. A read sampled at the third edge returns the new level.
- R11: A read of DATA_ADDR returns the output data register.
- R12: `rdata` is registered. It holds the selected value for the one cycle after an edge where `rd_en` was sampled high, and it is 0x00 after every edge where `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, active low, keeps register contents |
| hw_stby | input | 1 | Hardware standby, clears the registers and floats the pins |
| sw_stby | input | 1 | Software standby indication, keeps the registers and blocks writes |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_out | output | WIDTH | Pad output levels (output data register) |
| pin_oe | output | WIDTH | Pad output enables |

## Verification
The assertions check four things on every cycle. The output enables must be off during hardware standby. Writes must land one edge later and must be blocked under manual reset and software standby. Standby must clear the registers. Idle and unmapped reads must return zero. Only the bench's scenarios can show the per-bit mixing of latched data and pin levels in the port-read view. The same holds for the exact synchroniser latency and for the retained contents read back after a manual reset ends. Random traffic against a bench model of both registers covers the mixing under many direction patterns.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_DATA = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input int unsigned a,
                                            input int unsigned dir_a,
                                            input int unsigned data_a,
                                            input int unsigned pin_a);
      if (a == dir_a)       return SEL_DIR;
      else if (a == data_a) return SEL_DATA;
      else if (a == pin_a)  return SEL_PIN;
      else                  return SEL_NONE;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("gpio_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d;
               for (int s = 1; s < STAGES; s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             wr_en,
   input  reg_sel_e         wr_sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] data_q
);
   logic wr_allowed;

   // Only a running CPU may write: not held in manual reset or either standby.
   assign wr_allowed = wr_en & mrst_n & ~sw_stby & ~hw_stby;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else if (hw_stby) begin
         dir_q  <= '0;
         data_q <= '0;
      end else if (wr_allowed) begin
         if (wr_sel == SEL_DIR)  dir_q  <= wdata;
         if (wr_sel == SEL_DATA) data_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             hw_stby,
   input  logic             rd_en,
   input  reg_sel_e         rd_sel,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] port_view;
   logic [WIDTH-1:0] rd_next;

   // Per-bit choice between latched output value and pin level.
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_view
         assign port_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      unique case (rd_sel)
         SEL_DATA: rd_next = data_q;
         SEL_PIN:  rd_next = port_view;
         default:  rd_next = '0;   // direction is write-only; unmapped is zero
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rdata <= '0;
      end else if (!mrst_n || hw_stby || !rd_en) begin
         rdata <= '0;
      end else begin
         rdata <= rd_next;
      end
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 2,
   parameter int DIR_ADDR    = 0,
   parameter int DATA_ADDR   = 1,
   parameter int PIN_ADDR    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_port: WIDTH must be at least 1");
      end
      if (DIR_ADDR >= ADDR_SPAN || DATA_ADDR >= ADDR_SPAN || PIN_ADDR >= ADDR_SPAN) begin : g_bad_range
         $error("gpio_port: a register address does not fit in ADDR_W bits");
      end
      if (DIR_ADDR == DATA_ADDR || DIR_ADDR == PIN_ADDR || DATA_ADDR == PIN_ADDR) begin : g_bad_map
         $error("gpio_port: register addresses must be distinct");
      end
   endgenerate

   reg_sel_e         sel;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel = decode_addr(int'(addr), DIR_ADDR, DATA_ADDR, PIN_ADDR);

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .por_n   (por_n),
      .mrst_n  (mrst_n),
      .hw_stby (hw_stby),
      .sw_stby (sw_stby),
      .wr_en   (wr_en),
      .wr_sel  (sel),
      .wdata   (wdata),
      .dir_q   (dir_q),
      .data_q  (data_q)
   );

   gpio_readmux #(.WIDTH(WIDTH)) u_rd (
      .clk      (clk),
      .por_n    (por_n),
      .mrst_n   (mrst_n),
      .hw_stby  (hw_stby),
      .rd_en    (rd_en),
      .rd_sel   (sel),
      .dir_q    (dir_q),
      .data_q   (data_q),
      .pin_sync (pin_sync),
      .rdata    (rdata)
   );

   assign pin_out = data_q;
   assign pin_oe  = hw_stby ? '0 : dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH     = 8,
   parameter int ADDR_W    = 2,
   parameter int DIR_ADDR  = 0,
   parameter int DATA_ADDR = 1,
   parameter int PIN_ADDR  = 2
) (
   input logic              clk,
   input logic              por_n,
   input logic              mrst_n,
   input logic              hw_stby,
   input logic              sw_stby,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [WIDTH-1:0]  wdata,
   input logic [WIDTH-1:0]  rdata,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe
);
   logic unmapped;
   assign unmapped = (int'(addr) != DIR_ADDR) && (int'(addr) != DATA_ADDR) &&
                     (int'(addr) != PIN_ADDR);

   // R1: an accepted data write appears on pin_out after the edge
   p_data_write_r1: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && int'(addr) == DATA_ADDR && mrst_n && !hw_stby && !sw_stby)
      |=> pin_out == $past(wdata));

   // R3: unmapped and direction reads return zero
   p_zero_read_r3: assert property (@(posedge clk) disable iff (!por_n)
      (rd_en && (unmapped || int'(addr) == DIR_ADDR)) |=> rdata == '0);

   // R7: output enables are off throughout hardware standby
   p_oe_off_stby_r7: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |-> pin_oe == '0);

   // R7: standby clears the data register
   p_stby_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |=> pin_out == '0);

   // R8: manual reset holds the data register and clears the response
   p_mrst_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n && !hw_stby) |=> ($stable(pin_out) && rdata == '0));

   // R9: software standby holds the data register
   p_sw_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      (sw_stby && !hw_stby) |=> $stable(pin_out));

   // R12: no read strobe, zero response
   p_idle_zero_r12: assert property (@(posedge clk) disable iff (!por_n)
      !rd_en |=> rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR),
   .DATA_ADDR(DATA_ADDR), .PIN_ADDR(PIN_ADDR)
) u_chk (
   .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
   .sw_stby(sw_stby), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
   localparam int W = 8;
   localparam logic [1:0] A_DIR = 2'd0, A_DATA = 2'd1, A_PIN = 2'd2, A_NONE = 2'd3;

   logic clk = 1'b0;
   logic por_n = 1'b0, mrst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0;
   logic [1:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wdata = '0, pin_in = '0;
   logic [W-1:0] rdata, pin_out, pin_oe;

   int checks = 0, errors = 0;
   logic [W-1:0] m_dir = '0, m_data = '0;

   always #2 clk = ~clk;

   gpio_port dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe)
   );

   function automatic logic [W-1:0] port_view(input logic [W-1:0] d, input logic [W-1:0] v,
                                              input logic [W-1:0] p);
      return (d & v) | (~d & p);
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, sample 1 ns after the rising edge.
   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(posedge clk); #1; v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      void'($urandom(32'h5eed_0042));
      pin_in = 8'hA5;
      #1;
      chk("R6 reset pin_out", pin_out, 8'h00);
      chk("R6 reset pin_oe", pin_oe, 8'h00);
      chk("R6 reset rdata", rdata, 8'h00);
      idle(3);
      @(negedge clk); por_n = 1'b1;
      idle(3);

      // R4/R6: after reset all bits are inputs, view shows pins
      rd(A_PIN, v); chk("R4 R6 view after reset", v, 8'hA5);

      // R1, R2, R11
      wr(A_DATA, 8'h3C); chk("R1 pin_out", pin_out, 8'h3C);
      wr(A_DIR, 8'hF0);  chk("R2 pin_oe", pin_oe, 8'hF0);
      m_data = 8'h3C; m_dir = 8'hF0;
      rd(A_DATA, v); chk("R11 data readback", v, 8'h3C);
      rd(A_DIR, v);  chk("R3 dir reads zero", v, 8'h00);
      rd(A_NONE, v); chk("R3 unmapped reads zero", v, 8'h00);
      rd(A_PIN, v);  chk("R4 mixed view", v, port_view(m_dir, m_data, pin_in));
      idle(1);       chk("R12 idle rdata zero", rdata, 8'h00);

      // R5: writes to port-read and unmapped addresses have no effect
      wr(A_PIN, 8'hFF); wr(A_NONE, 8'h81);
      chk("R5 pin_out kept", pin_out, m_data);
      chk("R5 pin_oe kept", pin_oe, m_dir);
      rd(A_DATA, v); chk("R5 data kept", v, m_data);

      // R10: synchroniser latency (all inputs)
      wr(A_DIR, 8'h00); m_dir = 8'h00;
      pin_in = 8'h11; idle(3);
      @(negedge clk); pin_in = 8'hEE; addr = A_PIN; rd_en = 1'b1;
      @(posedge clk); #1; chk("R10 edge1 old", rdata, 8'h11);
      @(posedge clk); #1; chk("R10 edge2 old", rdata, 8'h11);
      @(posedge clk); #1; chk("R10 edge3 new", rdata, 8'hEE);
      @(negedge clk); rd_en = 1'b0;

      // R8: manual reset keeps registers, blocks writes, zero response
      wr(A_DIR, 8'h5A); wr(A_DATA, 8'hC3); m_dir = 8'h5A; m_data = 8'hC3;
      @(negedge clk); mrst_n = 1'b0;
      wr(A_DATA, 8'h00); wr(A_DIR, 8'hFF);
      chk("R8 pin_out held", pin_out, 8'hC3);
      chk("R8 pin_oe held", pin_oe, 8'h5A);
      rd(A_DATA, v); chk("R8 rdata zero in reset", v, 8'h00);
      @(negedge clk); mrst_n = 1'b1;
      rd(A_DATA, v); chk("R8 retained data", v, 8'hC3);

      // R9: software standby keeps registers, blocks writes
      @(negedge clk); sw_stby = 1'b1;
      wr(A_DATA, 8'h0F); wr(A_DIR, 8'h0F);
      chk("R9 pin_out held", pin_out, 8'hC3);
      chk("R9 pin_oe held", pin_oe, 8'h5A);
      @(negedge clk); sw_stby = 1'b0;
      rd(A_DATA, v); chk("R9 retained data", v, 8'hC3);

      // R7: hardware standby
      @(negedge clk); hw_stby = 1'b1; #1;
      chk("R7 oe off at once", pin_oe, 8'h00);
      @(posedge clk); #1;
      chk("R7 data cleared", pin_out, 8'h00);
      wr(A_DATA, 8'h77); wr(A_DIR, 8'h77);
      chk("R7 write ignored", pin_out, 8'h00);
      @(negedge clk); hw_stby = 1'b0; #1;
      chk("R7 dir cleared", pin_oe, 8'h00);
      m_dir = 8'h00; m_data = 8'h00;
      rd(A_PIN, v); chk("R7 view shows pins", v, pin_in);

      // R6: power-on reset mid-run acts without a clock edge
      wr(A_DATA, 8'h99); wr(A_DIR, 8'h99);
      @(negedge clk); por_n = 1'b0; #1;
      chk("R6 async pin_out", pin_out, 8'h00);
      chk("R6 async pin_oe", pin_oe, 8'h00);
      @(negedge clk); por_n = 1'b1;
      idle(3);

      // Random traffic against the model
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [W-1:0] r;
         op = $urandom_range(0, 5);
         r = W'($urandom);
         case (op)
            0: begin wr(A_DIR, r); m_dir = r; end
            1: begin wr(A_DATA, r); m_data = r; end
            2: begin wr($urandom_range(0, 1) ? A_PIN : A_NONE, r);
                     chk("R5 random ignored write", pin_out, m_data); end
            3: begin pin_in = r; idle(3); end
            4: begin rd(A_PIN, v); chk("R4 random view", v, port_view(m_dir, m_data, pin_in)); end
            default: begin
               rd(A_DATA, v); chk("R11 random data", v, m_data);
               chk("R2 random oe", pin_oe, m_dir);
            end
         endcase
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule